// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt Unit

This block turns the timing events of a real-time clock into ten maskable interrupt causes. Four causes follow the prescaler taps (32 Hz, 8 Hz, 4 Hz, 1 Hz). The other six are decoded from the time-of-day counters: the tens-of-seconds and tens-of-minutes rollovers, the one-minute and one-hour rollovers, the half-day boundary and the day boundary. The counter core reports each counter advance as a one-cycle step strobe, together with the value the counter holds just before it advances. The block decodes that value in binary or BCD coding, and in 24-hour or 12-hour hour format.

Software sees two registers on a small 16-bit register bus. One holds a per-cause enable mask. The other holds per-cause pending flags, which are cleared by writing 1. A single request line goes to the interrupt controller. It is high while any pending flag has its enable bit set.

Top module: `rtc_pint`

## Requirements
- R1: After reset every enable bit and every flag is 0, `irq` is 0, and both registers read 0.
- R2: A cause whose enable bit is 0 never sets its flag, whatever events arrive.
- R3: A cause whose enable bit is 1 has its flag read as 1 from the clock edge that samples its event, and `irq` rises at that edge.
- R4: Writing the flag register (address 1) clears each flag whose data bit is 1. A flag whose data bit is 0 is left unchanged. Without a write, a flag never drops.
- R5: If an event and a write-1 clear reach the same flag in one cycle, the flag ends up set.
- R6: Cause bit 4 (tens of seconds) fires on a seconds step from any value whose units digit is 9, including 59. Cause bit 6 (tens of minutes) does the same for minute steps. This holds in binary coding (`cfg_bcd`=0) and in BCD coding (`cfg_bcd`=1, units digit in bits 3:0).
- R7: Cause bit 5 fires on a seconds step from 59, and cause bit 7 fires on a minute step from 59.
- R8: In 24-hour mode (`cfg_12h`=0, `hr_now` holds hour 0..23), cause bit 8 fires on an hour step from 11 or 23, and cause bit 9 fires only on an hour step from 23.
- R9: In 12-hour mode (`cfg_12h`=1, `hr_now[4:0]` holds hour 1..12 and `hr_now[5]` is the PM marker), cause bit 8 fires on an hour step from 11 (AM or PM), and cause bit 9 fires only on a step from 11 PM.
- R10: `tap_tick` bits 0, 1, 2 and 3 (32 Hz, 8 Hz, 4 Hz and 1 Hz) feed cause bits 0, 1, 2 and 3, one flag set per tick.
- R11: `irq` equals the OR over all causes of (flag AND enable). Clearing an enable bit hides its pending flag from `irq` without clearing the flag.
- R12: The enable register (address 0) stores bits 9:0 of the written data. Bits 15:10 of both registers and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with `bus_sel` |
| bus_addr | input | 2 | Register address (0 enable, 1 flags) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` while `bus_sel` is high |
| cfg_bcd | input | 1 | 1: counter values are BCD coded |
| cfg_12h | input | 1 | 1: hour value is in 12-hour format with PM marker |
| tap_tick | input | 4 | Prescaler tick pulses: bit 0 32 Hz, 1 8 Hz, 2 4 Hz, 3 1 Hz |
| sec_step | input | 1 | Seconds counter advances this cycle |
| sec_now | input | 7 | Seconds value before the advance |
| min_step | input | 1 | Minutes counter advances this cycle |
| min_now | input | 7 | Minutes value before the advance |
| hr_step | input | 1 | Hours counter advances this cycle |
| hr_now | input | 6 | Hours value before the advance |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that a disabled cause never raises its flag, that an enabled event always lands, and that a written 1 clears a flag unless an event hits it in the same cycle. They also check that flags never drop without a write, and that the decoded causes nest correctly: a one-minute or one-hour event is always also a decade event, and a day event is always a half-day event. Only the bench's sweeps can show that the decoder picks exactly the right counter values: every seconds and minutes value in both codings, and every hour in both hour formats. The bench also covers the register map and the masking of `irq` by the enables.

// File: rtl/rtc_pint_pkg.sv
package rtc_pint_pkg;
   localparam int NUM_CAUSE = 10;
   localparam int TAP_N     = 4;
   localparam int SEC_W     = 7;
   localparam int HR_W      = 6;

   localparam int C_TEN_S = 4;
   localparam int C_MIN   = 5;
   localparam int C_TEN_M = 6;
   localparam int C_HOUR  = 7;
   localparam int C_HALF  = 8;
   localparam int C_DAY   = 9;

   typedef logic [NUM_CAUSE-1:0] cause_vec_t;
endpackage

// File: rtl/rtc_pint_decode.sv
module rtc_pint_decode
   import rtc_pint_pkg::*;
#(
   parameter bit BCD_SUPPORT = 1'b1
) (
   input  logic             cfg_bcd,
   input  logic             cfg_12h,
   input  logic [TAP_N-1:0] tap_tick,
   input  logic             sec_step,
   input  logic [SEC_W-1:0] sec_now,
   input  logic             min_step,
   input  logic [SEC_W-1:0] min_now,
   input  logic             hr_step,
   input  logic [HR_W-1:0]  hr_now,
   output cause_vec_t       ev
);
   logic use_bcd;

   generate
      if (BCD_SUPPORT) begin : g_bcd
         assign use_bcd = cfg_bcd;
      end else begin : g_bin
         logic unused_bcd;
         assign unused_bcd = cfg_bcd;
         assign use_bcd    = 1'b0;
      end
   endgenerate

   function automatic logic units_nine(input logic [SEC_W-1:0] v, input logic b);
      logic [SEC_W-1:0] r;
      r = v % SEC_W'(10);
      return b ? (v[3:0] == 4'd9) : (r == SEC_W'(9));
   endfunction

   function automatic logic at_59(input logic [SEC_W-1:0] v, input logic b);
      return b ? (v == SEC_W'(8'h59)) : (v == SEC_W'(59));
   endfunction

   logic [4:0] hr_field;
   logic       hr_pm;
   logic       h24_11, h24_23, h12_11;
   logic       half_hit, day_hit;

   always_comb begin
      hr_field = hr_now[4:0];
      hr_pm    = hr_now[5];
      h24_11   = use_bcd ? (hr_now == 6'h11) : (hr_now == 6'd11);
      h24_23   = use_bcd ? (hr_now == 6'h23) : (hr_now == 6'd23);
      h12_11   = use_bcd ? (hr_field == 5'h11) : (hr_field == 5'd11);
      if (cfg_12h) begin
         half_hit = h12_11;
         day_hit  = h12_11 && hr_pm;
      end else begin
         half_hit = h24_11 || h24_23;
         day_hit  = h24_23;
      end
   end

   always_comb begin
      ev             = '0;
      ev[TAP_N-1:0]  = tap_tick;
      ev[C_TEN_S]    = sec_step && units_nine(sec_now, use_bcd);
      ev[C_MIN]      = sec_step && at_59(sec_now, use_bcd);
      ev[C_TEN_M]    = min_step && units_nine(min_now, use_bcd);
      ev[C_HOUR]     = min_step && at_59(min_now, use_bcd);
      ev[C_HALF]     = hr_step && half_hit;
      ev[C_DAY]      = hr_step && day_hit;
   end
endmodule

// File: rtl/rtc_pint_regs.sv
module rtc_pint_regs
   import rtc_pint_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 2,
   parameter int EN_ADDR   = 0,
   parameter int FLAG_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  cause_vec_t        ev,
   output cause_vec_t        en_q,
   output cause_vec_t        flag_q
);
   localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_ADDR);
   localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

   logic wr_en, wr_flag;
   assign wr_en   = bus_sel && bus_wr && (bus_addr == EN_A);
   assign wr_flag = bus_sel && bus_wr && (bus_addr == FLAG_A);

   generate
      for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     en_q[i] <= 1'b0;
            else if (wr_en) en_q[i] <= bus_wdata[i];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= (ev[i] && en_q[i]) ||
                                     (flag_q[i] && !(wr_flag && bus_wdata[i]));
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && bus_addr == EN_A)   bus_rdata[NUM_CAUSE-1:0] = en_q;
      if (bus_sel && bus_addr == FLAG_A) bus_rdata[NUM_CAUSE-1:0] = flag_q;
   end
endmodule

// File: rtl/rtc_pint.sv
module rtc_pint
   import rtc_pint_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 2,
   parameter int EN_ADDR     = 0,
   parameter int FLAG_ADDR   = 1,
   parameter bit BCD_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cfg_bcd,
   input  logic              cfg_12h,
   input  logic [TAP_N-1:0]  tap_tick,
   input  logic              sec_step,
   input  logic [SEC_W-1:0]  sec_now,
   input  logic              min_step,
   input  logic [SEC_W-1:0]  min_now,
   input  logic              hr_step,
   input  logic [HR_W-1:0]   hr_now,
   output logic              irq
);
   generate
      if (DATA_W < NUM_CAUSE) begin : g_chk_w
         $error("rtc_pint: DATA_W too small for the cause count");
      end
      if (EN_ADDR == FLAG_ADDR) begin : g_chk_a
         $error("rtc_pint: enable and flag addresses collide");
      end
      if (EN_ADDR >= (1 << ADDR_W) || FLAG_ADDR >= (1 << ADDR_W)) begin : g_chk_r
         $error("rtc_pint: register address out of range");
      end
   endgenerate

   cause_vec_t ev_w, en_q, flag_q;

   rtc_pint_decode #(.BCD_SUPPORT(BCD_SUPPORT)) u_dec (
      .cfg_bcd (cfg_bcd),
      .cfg_12h (cfg_12h),
      .tap_tick(tap_tick),
      .sec_step(sec_step),
      .sec_now (sec_now),
      .min_step(min_step),
      .min_now (min_now),
      .hr_step (hr_step),
      .hr_now  (hr_now),
      .ev      (ev_w)
   );

   rtc_pint_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EN_ADDR(EN_ADDR), .FLAG_ADDR(FLAG_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .ev       (ev_w),
      .en_q     (en_q),
      .flag_q   (flag_q)
   );

   assign irq = |(flag_q & en_q);
endmodule

// File: rtl/rtc_pint_chk.sv
module rtc_pint_chk
   import rtc_pint_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 2,
   parameter int FLAG_ADDR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input cause_vec_t        ev,
   input cause_vec_t        en,
   input cause_vec_t        flags
);
   logic       wr_flag;
   cause_vec_t clr_mask;
   assign wr_flag  = bus_sel && bus_wr && (bus_addr == ADDR_W'(FLAG_ADDR));
   assign clr_mask = wr_flag ? bus_wdata[NUM_CAUSE-1:0] : '0;

   AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & ~$past(flags) & ~$past(en)) == '0));                 // R2
   AST_SET_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev & en) != '0) |=> ((flags & $past(ev & en)) == $past(ev & en)));    // R3
   AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_flag |=> ((flags & $past(clr_mask & ~(ev & en))) == '0));            // R4
   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_flag |=> ((~flags & $past(flags)) == '0));                          // R4
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_mask & ev & en) != '0) |=> ((flags & $past(clr_mask & ev & en)) != '0)); // R5
   AST_MIN_IS_DECADE: assert property (@(posedge clk) disable iff (!rst_n)
      ev[C_MIN] |-> ev[C_TEN_S]);                                             // R7
   AST_HOUR_IS_DECADE: assert property (@(posedge clk) disable iff (!rst_n)
      ev[C_HOUR] |-> ev[C_TEN_M]);                                            // R7
   AST_DAY_IS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      ev[C_DAY] |-> ev[C_HALF]);                                              // R8
endmodule

bind rtc_pint rtc_pint_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .ev       (ev_w),
   .en       (en_q),
   .flags    (flag_q)
);

// File: tb/tb_rtc_pint.sv
module tb_rtc_pint;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        cfg_bcd = 1'b0, cfg_12h = 1'b0;
   logic [3:0]  tap_tick = '0;
   logic        sec_step = 1'b0, min_step = 1'b0, hr_step = 1'b0;
   logic [6:0]  sec_now = '0, min_now = '0;
   logic [5:0]  hr_now = '0;
   logic        irq;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rtc_pint dut (.*);

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   // one-cycle event pulse; optional same-cycle write-1 clear of all flags
   task automatic pulse(input logic ss, input logic [6:0] sv, input logic ms, input logic [6:0] mv,
                        input logic hs, input logic [5:0] hv, input logic [3:0] tp, input logic clr);
      @(negedge clk);
      sec_step = ss; sec_now = sv; min_step = ms; min_now = mv;
      hr_step = hs; hr_now = hv; tap_tick = tp;
      if (clr) begin bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'hFFFF; end
      @(negedge clk);
      sec_step = 1'b0; min_step = 1'b0; hr_step = 1'b0; tap_tick = '0;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   function automatic logic [6:0] enc(input int v, input logic b);
      return b ? 7'(((v / 10) << 4) | (v % 10)) : 7'(v);
   endfunction

   initial begin
      logic [15:0] d, e;
      repeat (3) @(negedge clk);
      check("R1 irq after reset", {15'b0, irq}, 16'h0);
      rd(2'd0, d); check("R1 enable reset", d, 16'h0);
      rd(2'd1, d); check("R1 flag reset", d, 16'h0);
      rst_n = 1'b1;

      // R12 register map
      wr(2'd0, 16'hFFFF); rd(2'd0, d); check("R12 enable reserved bits", d, 16'h03FF);
      wr(2'd0, 16'h0155); rd(2'd0, d); check("R12 enable pattern", d, 16'h0155);
      rd(2'd2, d); check("R12 unmapped read", d, 16'h0);
      rd(2'd3, d); check("R12 unmapped read", d, 16'h0);

      // R2 all disabled: no flag set
      wr(2'd0, 16'h0000);
      pulse(1, 7'd59, 1, 7'd59, 1, 6'd23, 4'hF, 0);
      rd(2'd1, d); check("R2 disabled no flags", d, 16'h0);
      check("R2 irq stays low", {15'b0, irq}, 16'h0);
      wr(2'd0, 16'h0008);
      pulse(1, 7'd59, 1, 7'd59, 1, 6'd23, 4'hF, 0);
      rd(2'd1, d); check("R2 only enabled cause", d, 16'h0008);
      check("R3 irq raised", {15'b0, irq}, 16'h1);
      wr(2'd1, 16'hFFFF);

      // R10 taps, R3
      wr(2'd0, 16'h03FF);
      for (int t = 0; t < 4; t++) begin
         pulse(0, '0, 0, '0, 0, '0, 4'(1 << t), 0);
         rd(2'd1, d); check("R10 tap mapping", d, 16'(1 << t));
         check("R3 irq on tap", {15'b0, irq}, 16'h1);
         wr(2'd1, 16'(1 << t));
         rd(2'd1, d); check("R4 write-1 clear", d, 16'h0);
      end

      // R4 write 0 leaves, partial clear
      pulse(0, '0, 0, '0, 0, '0, 4'hF, 0);
      wr(2'd1, 16'h0000); rd(2'd1, d); check("R4 write 0 keeps", d, 16'h000F);
      wr(2'd1, 16'h0005); rd(2'd1, d); check("R4 partial clear", d, 16'h000A);

      // R11 enable masks irq, flag kept
      wr(2'd0, 16'h03F5); check("R11 irq masked", {15'b0, irq}, 16'h0);
      rd(2'd1, d); check("R11 flag kept", d, 16'h000A);
      wr(2'd0, 16'h03FF); check("R11 irq unmasked", {15'b0, irq}, 16'h1);
      wr(2'd1, 16'hFFFF); check("R11 irq after clear", {15'b0, irq}, 16'h0);

      // R5 set wins over same-cycle clear
      pulse(0, '0, 0, '0, 0, '0, 4'h3, 0);
      pulse(1, 7'd59, 0, '0, 0, '0, 4'h0, 1);
      rd(2'd1, d); check("R5 set beats clear", d, 16'h0030);
      wr(2'd1, 16'hFFFF);

      // R6/R7 sweeps over seconds and minutes, binary and BCD
      for (int b = 0; b < 2; b++) begin
         cfg_bcd = b[0];
         for (int v = 0; v < 60; v++) begin
            pulse(1, enc(v, b[0]), 0, '0, 0, '0, 4'h0, 0);
            e = '0; e[4] = (v % 10 == 9); e[5] = (v == 59);
            rd(2'd1, d); check(e[5] ? "R7 seconds 59" : "R6 seconds decade", d, e);
            wr(2'd1, 16'hFFFF);
            pulse(0, '0, 1, enc(v, b[0]), 0, '0, 4'h0, 0);
            e = '0; e[6] = (v % 10 == 9); e[7] = (v == 59);
            rd(2'd1, d); check(e[7] ? "R7 minutes 59" : "R6 minutes decade", d, e);
            wr(2'd1, 16'hFFFF);
         end
      end

      // R8 24-hour sweep
      for (int b = 0; b < 2; b++) begin
         cfg_bcd = b[0]; cfg_12h = 1'b0;
         for (int h = 0; h < 24; h++) begin
            pulse(0, '0, 0, '0, 1, 6'(enc(h, b[0])), 4'h0, 0);
            e = '0; e[8] = (h == 11 || h == 23); e[9] = (h == 23);
            rd(2'd1, d); check("R8 24h hour", d, e);
            wr(2'd1, 16'hFFFF);
         end
      end

      // R9 12-hour sweep
      for (int b = 0; b < 2; b++) begin
         cfg_bcd = b[0]; cfg_12h = 1'b1;
         for (int pm = 0; pm < 2; pm++) begin
            for (int h = 1; h <= 12; h++) begin
               pulse(0, '0, 0, '0, 1, {pm[0], enc(h, b[0])[4:0]}, 4'h0, 0);
               e = '0; e[8] = (h == 11); e[9] = (h == 11 && pm == 1);
               rd(2'd1, d); check("R9 12h hour", d, e);
               wr(2'd1, 16'hFFFF);
            end
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule